// File: doc/BRIEF.md
# Address Window Target Decoder

This block decides which target interface owns each 32-bit system address. Software programs eight windows through a small register write port. Each window has a base and an attribute word. The attribute word holds an enable flag, a 4-bit target number and a 6-bit size exponent. Each window covers a naturally aligned power-of-two region from 4 KB to 2 GB.

Two regions are decoded apart from the windows. The first is a 1 MB configuration-register region, placed by a 12-bit relocatable base. The second is the fixed top 8 MB of the space, which always reaches the boot ROM.

A requester presents an address with a valid strobe. One clock later the block returns the chosen target number, a hit flag and a miss flag. Running the transaction on the chosen target is handled elsewhere, and so is arbitration between targets.

Top module: `addr_window_map`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_hit`, `rsp_miss` and `rsp_target` are 0. All windows are disabled. The configuration base resets to 12'hFF7.
- R2: A request sampled with `req_valid` high gives `rsp_valid` high on the next clock, and exactly one of `rsp_hit` and `rsp_miss` is high in that cycle. With no request, all response outputs are 0 in the following cycle.
- R3: A window with size code S covers 2^(S+1) bytes, aligned to that size. The base bits below the size boundary are ignored when matching.
- R4: A window takes part in decoding only while its enable bit (attribute bit 31) is 1.
- R5: Size codes below 11 (smaller than 4 KB) or above 30 (larger than 2 GB) disable the window.
- R6: When several windows match an address, the lowest-numbered window supplies the target.
- R7: An address whose bits 31:20 equal the configuration base hits with target 4'b1110. This region wins over the boot region and over every window.
- R8: An address at or above 0xFF80_0000 that is not in the configuration region hits with target 4'b1000, even if a window also matches it.
- R9: Register write encoding. `wr_addr[4]`=1 writes the configuration base from `wr_data[11:0]`. Otherwise `wr_addr[3:1]` selects the window. With `wr_addr[0]`=0, `wr_data[19:0]` is written as the window's address bits 31:12. With `wr_addr[0]`=1, the attribute word is written: bit 31 is enable, bits 23:20 are the target and bits 5:0 are the size code.
- R10: An address matched by no region raises `rsp_miss` with `rsp_target` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register select (see R9) |
| wr_data | input | 32 | Register write data |
| req_valid | input | 1 | Address-phase valid |
| req_addr | input | 32 | Address to decode |
| rsp_valid | output | 1 | Decode result valid |
| rsp_target | output | 4 | Selected target number |
| rsp_hit | output | 1 | Address mapped |
| rsp_miss | output | 1 | Address unmapped |

## Verification
A corrupted window register or a wrong mask shows up as a wrong target or a false miss. It appears in the cycle after the first request that lands in the affected range, so the bench sweeps the edges of every window and a long pseudo-random address run. Priority faults only show where regions overlap, so windows are placed overlapping each other and also overlapping the configuration and boot regions. The expected result comes from range arithmetic, not from bit masks.

// File: rtl/addr_window_map.sv
module addr_window_map #(
  parameter int NWIN = 8,
  parameter int TIDW = 4,
  parameter logic [TIDW-1:0] CFG_TID = TIDW'(14),
  parameter logic [TIDW-1:0] BOOT_TID = TIDW'(8),
  parameter logic [11:0] CFG_RST = 12'hFF7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [4:0]      wr_addr,
  input  logic [31:0]     wr_data,
  input  logic            req_valid,
  input  logic [31:0]     req_addr,
  output logic            rsp_valid,
  output logic [TIDW-1:0] rsp_target,
  output logic            rsp_hit,
  output logic            rsp_miss
);
  localparam int IW = $clog2(NWIN);

  logic [19:0]     base_q [NWIN];
  logic            en_q   [NWIN];
  logic [TIDW-1:0] tid_q  [NWIN];
  logic [5:0]      size_q [NWIN];
  logic [11:0]     cfg_q;
  logic [NWIN-1:0] win_hit;
  logic [IW-1:0]   wsel;

  assign wsel = wr_addr[IW:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
      for (int i = 0; i < NWIN; i++) begin
        base_q[i] <= '0;
        en_q[i]   <= 1'b0;
        tid_q[i]  <= '0;
        size_q[i] <= '0;
      end
    end else if (wr_en) begin
      if (wr_addr[4]) cfg_q <= wr_data[11:0];
      else if (wr_addr[0]) begin
        en_q[wsel]   <= wr_data[31];
        tid_q[wsel]  <= wr_data[20 +: TIDW];
        size_q[wsel] <= wr_data[5:0];
      end else base_q[wsel] <= wr_data[19:0];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NWIN; g++) begin : g_win
      logic [4:0]  sh;
      logic [19:0] mask;
      logic        size_ok;
      assign sh      = 5'(size_q[g] - 6'd11);
      assign size_ok = (size_q[g] >= 6'd11) && (size_q[g] <= 6'd30);
      assign mask    = 20'hFFFFF << sh;
      assign win_hit[g] = en_q[g] && size_ok &&
                          (((req_addr[31:12] ^ base_q[g]) & mask) == 20'd0);
    end
  endgenerate

  logic            any_win;
  logic [TIDW-1:0] win_tid;
  always_comb begin
    any_win = 1'b0;
    win_tid = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (win_hit[i]) begin
        any_win = 1'b1;
        win_tid = tid_q[i];
      end
    end
  end

  logic            cfg_hit, boot_hit, any_hit;
  logic [TIDW-1:0] nxt_tid;
  assign cfg_hit  = req_addr[31:20] == cfg_q;
  assign boot_hit = &req_addr[31:23];
  assign any_hit  = cfg_hit || boot_hit || any_win;
  assign nxt_tid  = cfg_hit ? CFG_TID : boot_hit ? BOOT_TID : any_win ? win_tid : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_target <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= req_valid && any_hit;
      rsp_miss   <= req_valid && !any_hit;
      rsp_target <= req_valid ? nxt_tid : '0;
    end
  end
endmodule

// File: rtl/addr_window_map_chk.sv
module addr_window_map_chk #(
  parameter int TIDW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [31:0]     req_addr,
  input logic            rsp_valid,
  input logic [TIDW-1:0] rsp_target,
  input logic            rsp_hit,
  input logic            rsp_miss
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss));
  // R2
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss}));
  // R8
  boot_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (&req_addr[31:23])) |=> rsp_hit);
  // R10
  miss_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_target == '0));
endmodule

bind addr_window_map addr_window_map_chk #(.TIDW(TIDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_target(rsp_target), .rsp_hit(rsp_hit),
  .rsp_miss(rsp_miss));

// File: tb/addr_window_map_bench.sv
module addr_window_map_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [3:0]  rsp_target;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [19:0] m_base [8];
  logic        m_en   [8];
  logic [3:0]  m_tid  [8];
  logic [5:0]  m_size [8];
  logic [11:0] m_cfg;

  always #4 clk = ~clk;

  addr_window_map u_addr_window_map (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_target(rsp_target), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss));

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R9 encoding: base at {0,idx,0}, attribute at {0,idx,1}
  task automatic setwin(input int i, input logic [19:0] b, input logic en,
                        input logic [3:0] t, input logic [5:0] s);
    wreg({1'b0, 3'(i), 1'b0}, {12'd0, b});
    wreg({1'b0, 3'(i), 1'b1}, {en, 7'd0, t, 14'd0, s});
    m_base[i] = b; m_en[i] = en; m_tid[i] = t; m_size[i] = s;
  endtask

  task automatic setcfg(input logic [11:0] c);
    wreg(5'b10000, {20'd0, c});
    m_cfg = c;
  endtask

  function automatic void model(input logic [31:0] a, output bit h, output logic [3:0] t);
    longint unsigned sz, st, ad;
    h = 0; t = 4'd0;
    ad = longint'(a);
    if (a[31:20] == m_cfg) begin h = 1; t = 4'd14; return; end
    if (ad >= 64'hFF80_0000) begin h = 1; t = 4'd8; return; end
    for (int i = 0; i < 8; i++) begin
      if (m_en[i] && m_size[i] >= 11 && m_size[i] <= 30) begin
        sz = 64'd1 << (m_size[i] + 1);
        st = ((longint'(m_base[i]) * 4096) / sz) * sz;
        if (ad >= st && ad < st + sz) begin h = 1; t = m_tid[i]; return; end
      end
    end
  endfunction

  task automatic look(input logic [31:0] a, input string tag);
    bit h; logic [3:0] t;
    model(a, h, t);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    n_cmp++;
    if (rsp_valid !== 1'b1 || rsp_hit !== h || rsp_miss !== !h || rsp_target !== t) begin
      n_bad++;
      $display("FAIL %s addr=%h got v=%b h=%b m=%b t=%h exp h=%b t=%h",
               tag, a, rsp_valid, rsp_hit, rsp_miss, rsp_target, h, t);
    end
  endtask

  task automatic edges(input int i, input string tag);
    longint unsigned sz, st;
    sz = 64'd1 << (m_size[i] + 1);
    st = ((longint'(m_base[i]) * 4096) / sz) * sz;
    look(32'(st), tag);
    look(32'(st + sz - 1), tag);
    look(32'(st + sz), tag);
    if (st != 0) look(32'(st - 1), tag);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    for (int i = 0; i < 8; i++) begin
      m_base[i] = '0; m_en[i] = 0; m_tid[i] = '0; m_size[i] = '0;
    end
    m_cfg = 12'hFF7;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset outputs
    n_cmp++;
    if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_miss !== 0 || rsp_target !== 0) begin
      n_bad++;
      $display("FAIL R1 reset outputs v=%b h=%b m=%b t=%h exp 0", rsp_valid, rsp_hit, rsp_miss, rsp_target);
    end
    look(32'h0000_1000, "R1");
    look(32'hFF70_0000, "R1");
    look(32'h8000_0000, "R10");
    // R2 idle after a request
    @(negedge clk);
    n_cmp++;
    if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_miss !== 0) begin
      n_bad++;
      $display("FAIL R2 idle v=%b h=%b m=%b exp 0", rsp_valid, rsp_hit, rsp_miss);
    end

    setwin(0, 20'h00000, 1, 4'hF, 6'h1A);
    setwin(1, 20'hE0000, 1, 4'h0, 6'h1B);
    setwin(2, 20'hF8000, 1, 4'h4, 6'h19);
    setwin(3, 20'h40345, 1, 4'h3, 6'h13);
    setwin(4, 20'h01000, 1, 4'h5, 6'h0F);
    setwin(5, 20'h30000, 0, 4'h6, 6'h0E);
    setwin(6, 20'h50000, 1, 4'h7, 6'h0A);
    setwin(7, 20'h60000, 1, 4'h9, 6'h1F);
    edges(0, "R3"); edges(1, "R3"); edges(2, "R3"); edges(3, "R3");
    look(32'h4034_5000, "R3");
    look(32'h4030_0000, "R3");
    look(32'h0100_0000, "R6");
    look(32'h0100_8000, "R6");
    look(32'h3000_0000, "R4");
    look(32'h5000_0000, "R5");
    look(32'h6000_0000, "R5");
    look(32'hFF70_0010, "R7");
    look(32'hFF80_0000, "R8");
    look(32'hFFFF_FFFF, "R8");
    look(32'h2000_0000, "R10");

    setwin(0, 20'h00000, 0, 4'hF, 6'h1A);
    look(32'h0100_0000, "R4");
    look(32'h0010_0000, "R4");
    edges(4, "R3");
    setwin(6, 20'h50000, 1, 4'h7, 6'h0B);
    edges(6, "R5");
    setwin(7, 20'h80000, 1, 4'h9, 6'h1E);
    look(32'hE000_0000, "R6");
    look(32'h9000_0000, "R6");
    look(32'hFF90_0000, "R8");
    setcfg(12'h001);
    look(32'h0010_0040, "R7");
    look(32'h0020_0000, "R9");
    setcfg(12'hFF8);
    look(32'hFF80_0004, "R7");
    look(32'hFF90_0000, "R8");
    look(32'hFF70_0000, "R9");

    lcg = 32'h1234_5678;
    for (int k = 0; k < 1500; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      look(lcg, "R3");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule